// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the per-processor cache controller for a small bus-based shared-memory multiprocessor. A direct-mapped, write-back array holds one data word per line. Coherence uses write-invalidate with three line states. The processor side makes load and store requests and waits until the controller returns a ready pulse. The bus side asks an external arbiter for the shared bus. Once it has a grant, it drives one command. In every cycle it is not driving, it watches the commands that other agents place on the bus.

A miss always takes two steps: first win the bus, then issue the command. The cache array is left untouched until the grant arrives. If the line being replaced holds dirty data, a writeback command goes out first. When another cache misses on a line held dirty here, this controller answers in the cycle after the command, sending its data and an ownership flag. The data source on the bus uses that flag in place of its own stale copy.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: A load to a line in Shared (code 1) or Exclusive (code 2), or a store to an Exclusive line, completes with `cpu_ready` in the cycle after it is accepted, and no bus command is issued.
- R2: A load to an Invalid (code 0) line or a tag mismatch issues a read-miss command (`bus_cmd_o` = 2'b01) for the requested address. The line is filled in Shared and the word is returned.
- R3: A store to a Shared or Invalid line issues a write-miss command (2'b10). The line becomes Exclusive and holds the stored word.
- R4: A snooped write-miss whose tag matches a valid local line moves that line to Invalid. The next local load of it misses and returns the newer value.
- R5: A snooped read-miss or write-miss that hits an Exclusive line raises `snp_own_o` with the line's data exactly one cycle after the command. After a read-miss the line stays readable as Shared.
- R6: The controller drives a command only while `bus_gnt` is high. It holds `bus_req` until the access completes, and it changes nothing in its array before the grant.
- R7: Stores from two processors racing for the same address are ordered by the bus. Afterwards both caches read the same value, and that value is one of the two stored.
- R8: A miss that replaces an Exclusive line with another tag issues a writeback (2'b11) carrying the victim's address and data, in the cycle right before the miss command. A clean victim is dropped with no writeback.
- R9: `cpu_ready` is a one-cycle pulse, and `cpu_rdata` is valid with it.
- R10: After reset every line is Invalid, and `cpu_ready`, `bus_req`, `bus_valid_o` and `snp_own_o` are low.
- R11: Across any sequence of single accesses from either processor, every load returns the last value stored to that address.
- R12: A snoop update to the array and a local update to the array never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present; held until `cpu_ready` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Load result, valid with `cpu_ready` |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_valid_o | output | 1 | This controller drives a command this cycle |
| bus_cmd_o | output | 2 | Command: 01 read-miss, 10 write-miss, 11 writeback |
| bus_addr_o | output | AW | Command address |
| bus_wdata_o | output | DW | Writeback data |
| bus_valid_i | input | 1 | Some agent drives a command this cycle |
| bus_cmd_i | input | 2 | Command seen on the bus |
| bus_addr_i | input | AW | Address seen on the bus |
| snp_own_o | output | 1 | This cache supplies dirty data for the previous command |
| snp_data_o | output | DW | Data supplied with `snp_own_o` |
| rsp_own_i | input | 1 | Some cache supplied data for the previous command |
| rsp_odata_i | input | DW | Data from the supplying cache |
| rsp_mdata_i | input | DW | Data from memory for the previous command |

## Verification
The assertions assume that the arbiter holds a grant for as long as the granted requester keeps `bus_req` high, and that it never grants two agents at once. They also assume that memory and owner data arrive one cycle after a miss command, and that no foreign command appears while this controller holds the bus. The bench keeps within this. It uses a locking arbiter that re-arbitrates only after the holder drops its request. It registers memory data on the command edge. It holds every processor request stable until its ready pulse.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/snoop_line_store.sv
module snoop_line_store
  import snoop_pkg::*;
#(
  parameter int SETS = 4,
  parameter int TW   = 4,
  parameter int DW   = 16,
  localparam int IW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] a_idx,
  output logic [TW-1:0] a_tag,
  output line_st_t      a_st,
  output logic [DW-1:0] a_data,
  input  logic [IW-1:0] b_idx,
  output logic [TW-1:0] b_tag,
  output line_st_t      b_st,
  output logic [DW-1:0] b_data,
  input  logic          we,
  input  logic [IW-1:0] w_idx,
  input  logic [TW-1:0] w_tag,
  input  line_st_t      w_st,
  input  logic [DW-1:0] w_data
);
  logic [TW-1:0] tag_mem  [SETS];
  logic [DW-1:0] data_mem [SETS];
  line_st_t      st_mem   [SETS];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx]  <= w_tag;
      data_mem[w_idx] <= w_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) st_mem[i] <= LN_INV;
    end else if (we) begin
      st_mem[w_idx] <= w_st;
    end
  end

  assign a_tag  = tag_mem[a_idx];
  assign a_st   = st_mem[a_idx];
  assign a_data = data_mem[a_idx];
  assign b_tag  = tag_mem[b_idx];
  assign b_st   = st_mem[b_idx];
  assign b_data = data_mem[b_idx];
endmodule

// File: rtl/snoop_watch.sv
module snoop_watch
  import snoop_pkg::*;
#(
  parameter int AW   = 6,
  parameter int SETS = 4,
  parameter int DW   = 16,
  localparam int IW  = $clog2(SETS),
  localparam int TW  = AW - IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid_i,
  input  logic          bus_mine_i,
  input  logic [1:0]    bus_cmd_i,
  input  logic [AW-1:0] bus_addr_i,
  output logic [IW-1:0] snp_idx,
  input  logic [TW-1:0] line_tag,
  input  line_st_t      line_st,
  input  logic [DW-1:0] line_data,
  output logic          upd,
  output line_st_t      upd_st,
  output logic          own_o,
  output logic [DW-1:0] own_data_o
);
  logic foreign, tag_hit, supply;

  assign snp_idx = bus_addr_i[IW-1:0];
  assign foreign = bus_valid_i && !bus_mine_i;
  assign tag_hit = foreign && (line_st != LN_INV) && (line_tag == bus_addr_i[AW-1:IW]);

  always_comb begin
    upd    = 1'b0;
    upd_st = line_st;
    supply = 1'b0;
    if (tag_hit) begin
      if (bus_cmd_i == BC_RDMISS && line_st == LN_EXC) begin
        upd    = 1'b1;
        upd_st = LN_SHR;
        supply = 1'b1;
      end else if (bus_cmd_i == BC_WRMISS) begin
        upd    = 1'b1;
        upd_st = LN_INV;
        supply = (line_st == LN_EXC);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_o      <= 1'b0;
      own_data_o <= '0;
    end else begin
      own_o      <= supply;
      own_data_o <= supply ? line_data : '0;
    end
  end

  // R5: an ownership response only ever follows a foreign command by one cycle
  own_window_chk: assert property (@(posedge clk) disable iff (rst)
    own_o |-> $past(bus_valid_i && !bus_mine_i && bus_cmd_i != BC_WBACK));
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import snoop_pkg::*;
#(
  parameter int AW   = 6,
  parameter int DW   = 16,
  parameter int SETS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  input  logic          cpu_write,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_valid_o,
  output logic [1:0]    bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_valid_i,
  input  logic [1:0]    bus_cmd_i,
  input  logic [AW-1:0] bus_addr_i,
  output logic          snp_own_o,
  output logic [DW-1:0] snp_data_o,
  input  logic          rsp_own_i,
  input  logic [DW-1:0] rsp_odata_i,
  input  logic [DW-1:0] rsp_mdata_i
);
  localparam int IW = $clog2(SETS);
  localparam int TW = AW - IW;

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_WBC, S_MSC, S_RESP} fsm_t;
  fsm_t state;

  logic          req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;

  logic [IW-1:0] a_idx, b_idx, w_idx;
  logic [TW-1:0] a_tag, b_tag, w_tag;
  line_st_t      a_st, b_st, w_st, snp_st;
  logic [DW-1:0] a_data, b_data, w_data;
  logic          we, snp_upd, own_we;
  logic [TW-1:0] own_tag;
  line_st_t      own_st;
  logic [DW-1:0] own_data, fill_data;

  logic accept, tag_ok, rd_hit, wr_hit, snoop_busy;

  assign a_idx      = (state == S_IDLE) ? cpu_addr[IW-1:0] : req_addr[IW-1:0];
  assign snoop_busy = bus_valid_i && !bus_valid_o;
  assign accept     = (state == S_IDLE) && cpu_valid && !cpu_ready && !snoop_busy;
  assign tag_ok     = (a_st != LN_INV) && (a_tag == cpu_addr[AW-1:IW]);
  assign rd_hit     = !cpu_write && tag_ok;
  assign wr_hit     = cpu_write && tag_ok && (a_st == LN_EXC);
  assign fill_data  = rsp_own_i ? rsp_odata_i : rsp_mdata_i;

  snoop_line_store #(.SETS(SETS), .TW(TW), .DW(DW)) u_store (
    .clk(clk), .rst(rst),
    .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
    .b_idx(b_idx), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
    .we(we), .w_idx(w_idx), .w_tag(w_tag), .w_st(w_st), .w_data(w_data)
  );

  snoop_watch #(.AW(AW), .SETS(SETS), .DW(DW)) u_watch (
    .clk(clk), .rst(rst),
    .bus_valid_i(bus_valid_i), .bus_mine_i(bus_valid_o),
    .bus_cmd_i(bus_cmd_i), .bus_addr_i(bus_addr_i),
    .snp_idx(b_idx), .line_tag(b_tag), .line_st(b_st), .line_data(b_data),
    .upd(snp_upd), .upd_st(snp_st),
    .own_o(snp_own_o), .own_data_o(snp_data_o)
  );

  // local array updates: store hit, victim drop, line fill
  always_comb begin
    own_we   = 1'b0;
    own_tag  = a_tag;
    own_st   = a_st;
    own_data = a_data;
    case (state)
      S_IDLE: if (accept && wr_hit) begin
        own_we   = 1'b1;
        own_tag  = cpu_addr[AW-1:IW];
        own_st   = LN_EXC;
        own_data = cpu_wdata;
      end
      S_WBC: begin
        own_we = 1'b1;
        own_st = LN_INV;
      end
      S_RESP: begin
        own_we   = 1'b1;
        own_tag  = req_addr[AW-1:IW];
        own_st   = req_we ? LN_EXC : LN_SHR;
        own_data = req_we ? req_wdata : fill_data;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (snp_upd) begin
      we = 1'b1; w_idx = b_idx; w_tag = b_tag; w_st = snp_st; w_data = b_data;
    end else begin
      we = own_we; w_idx = a_idx; w_tag = own_tag; w_st = own_st; w_data = own_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      cpu_ready   <= 1'b0;
      cpu_rdata   <= '0;
      bus_req     <= 1'b0;
      bus_valid_o <= 1'b0;
      bus_cmd_o   <= BC_NONE;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      req_we      <= 1'b0;
      req_addr    <= '0;
      req_wdata   <= '0;
    end else begin
      cpu_ready   <= 1'b0;
      bus_valid_o <= 1'b0;
      bus_cmd_o   <= BC_NONE;
      case (state)
        S_IDLE: if (accept) begin
          req_we    <= cpu_write;
          req_addr  <= cpu_addr;
          req_wdata <= cpu_wdata;
          if (rd_hit || wr_hit) begin
            cpu_ready <= 1'b1;
            cpu_rdata <= cpu_write ? cpu_wdata : a_data;
          end else begin
            bus_req <= 1'b1;
            state   <= S_ARB;
          end
        end
        S_ARB: if (bus_gnt) begin
          bus_valid_o <= 1'b1;
          if (a_st == LN_EXC && a_tag != req_addr[AW-1:IW]) begin
            bus_cmd_o   <= BC_WBACK;
            bus_addr_o  <= {a_tag, req_addr[IW-1:0]};
            bus_wdata_o <= a_data;
            state       <= S_WBC;
          end else begin
            bus_cmd_o  <= req_we ? BC_WRMISS : BC_RDMISS;
            bus_addr_o <= req_addr;
            state      <= S_MSC;
          end
        end
        S_WBC: begin
          bus_valid_o <= 1'b1;
          bus_cmd_o   <= req_we ? BC_WRMISS : BC_RDMISS;
          bus_addr_o  <= req_addr;
          state       <= S_MSC;
        end
        S_MSC: state <= S_RESP;
        S_RESP: begin
          cpu_ready <= 1'b1;
          cpu_rdata <= req_we ? req_wdata : fill_data;
          bus_req   <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  cmd_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o |-> (bus_gnt && bus_req));
  // R6
  req_until_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) |-> cpu_ready);
  // R8
  wb_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && bus_cmd_o == BC_WBACK) |=> (bus_valid_o && bus_cmd_o != BC_WBACK && bus_cmd_o != BC_NONE));
  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R12
  no_wr_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(snp_upd && own_we));
endmodule

// File: tb/snoop_cache_ctrl_test.sv
module snoop_cache_ctrl_test;
  localparam int AW = 6, DW = 16, SETS = 4;
  localparam int NADDR = 16;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic          cv [2];
  logic          cw [2];
  logic [AW-1:0] ca [2];
  logic [DW-1:0] cd [2];
  logic          crdy [2];
  logic [DW-1:0] crd [2];
  logic          breq [2];
  logic          gnt [2];
  logic          bvo [2];
  logic [1:0]    bcmd [2];
  logic [AW-1:0] badr [2];
  logic [DW-1:0] bwd [2];
  logic          own [2];
  logic [DW-1:0] odat [2];

  logic          bus_v, rsp_own;
  logic [1:0]    bus_c;
  logic [AW-1:0] bus_a;
  logic [DW-1:0] bus_w, rsp_od, mdata;
  logic [AW-1:0] resp_addr;

  assign bus_v   = bvo[0] | bvo[1];
  assign bus_c   = bvo[0] ? bcmd[0] : bcmd[1];
  assign bus_a   = bvo[0] ? badr[0] : badr[1];
  assign bus_w   = bvo[0] ? bwd[0]  : bwd[1];
  assign rsp_own = own[0] | own[1];
  assign rsp_od  = own[0] ? odat[0] : odat[1];

  for (genvar g = 0; g < 2; g++) begin : g_cpu
    if (g == 0) begin : g_uut
      snoop_cache_ctrl #(.AW(AW), .DW(DW), .SETS(SETS)) uut (
        .clk(clk), .rst(rst), .cpu_valid(cv[g]), .cpu_write(cw[g]), .cpu_addr(ca[g]),
        .cpu_wdata(cd[g]), .cpu_ready(crdy[g]), .cpu_rdata(crd[g]), .bus_req(breq[g]),
        .bus_gnt(gnt[g]), .bus_valid_o(bvo[g]), .bus_cmd_o(bcmd[g]), .bus_addr_o(badr[g]),
        .bus_wdata_o(bwd[g]), .bus_valid_i(bus_v), .bus_cmd_i(bus_c), .bus_addr_i(bus_a),
        .snp_own_o(own[g]), .snp_data_o(odat[g]), .rsp_own_i(rsp_own),
        .rsp_odata_i(rsp_od), .rsp_mdata_i(mdata));
    end else begin : g_peer
      snoop_cache_ctrl #(.AW(AW), .DW(DW), .SETS(SETS)) peer (
        .clk(clk), .rst(rst), .cpu_valid(cv[g]), .cpu_write(cw[g]), .cpu_addr(ca[g]),
        .cpu_wdata(cd[g]), .cpu_ready(crdy[g]), .cpu_rdata(crd[g]), .bus_req(breq[g]),
        .bus_gnt(gnt[g]), .bus_valid_o(bvo[g]), .bus_cmd_o(bcmd[g]), .bus_addr_o(badr[g]),
        .bus_wdata_o(bwd[g]), .bus_valid_i(bus_v), .bus_cmd_i(bus_c), .bus_addr_i(bus_a),
        .snp_own_o(own[g]), .snp_data_o(odat[g]), .rsp_own_i(rsp_own),
        .rsp_odata_i(rsp_od), .rsp_mdata_i(mdata));
    end
  end

  // locking arbiter with rotating priority
  logic pri, hold_off;
  always @(posedge clk) begin
    if (rst) begin
      gnt[0] <= 1'b0; gnt[1] <= 1'b0; pri <= 1'b0;
    end else if (gnt[0] && breq[0]) begin
    end else if (gnt[1] && breq[1]) begin
    end else begin
      gnt[0] <= 1'b0; gnt[1] <= 1'b0;
      if (!hold_off) begin
        if (breq[0] && (!breq[1] || !pri)) begin gnt[0] <= 1'b1; pri <= 1'b1; end
        else if (breq[1]) begin gnt[1] <= 1'b1; pri <= 1'b0; end
      end
    end
  end

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 37 + 5);
  endfunction

  // memory responder
  logic [DW-1:0] mem [1 << AW];
  initial for (int i = 0; i < (1 << AW); i++) mem[i] = init_val(i);
  always @(posedge clk) begin
    if (bus_v && (bus_c == 2'b01 || bus_c == 2'b10)) begin
      mdata <= mem[bus_a];
      resp_addr <= bus_a;
    end
    if (bus_v && bus_c == 2'b11) mem[bus_a] <= bus_w;
    if (rsp_own) mem[resp_addr] <= rsp_od;
  end

  // bus monitor
  int n_rd = 0, n_wr = 0, n_wb = 0, n_own = 0, n_wbseq = 0, n_nogrant = 0;
  logic prev_wb = 1'b0;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  always @(negedge clk) begin
    if (!rst) begin
      if ((bvo[0] && !gnt[0]) || (bvo[1] && !gnt[1])) n_nogrant++;
      if (bus_v && bus_c == 2'b01) n_rd++;
      if (bus_v && bus_c == 2'b10) n_wr++;
      if (bus_v && bus_c == 2'b11) begin n_wb++; wb_addr = bus_a; wb_data = bus_w; end
      if (prev_wb && bus_v && (bus_c == 2'b01 || bus_c == 2'b10)) n_wbseq++;
      prev_wb = bus_v && bus_c == 2'b11;
      if (rsp_own) n_own++;
    end
  end

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [DW-1:0] gold [NADDR];
  int last_cyc;

  task automatic access(input int c, input bit we, input int a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd);
    int cyc = 0;
    @(negedge clk);
    cv[c] = 1'b1; cw[c] = we; ca[c] = AW'(a); cd[c] = d;
    do begin @(negedge clk); cyc++; end while (!crdy[c] && cyc < 300);
    rd = crd[c];
    cv[c] = 1'b0;
    last_cyc = cyc;
    if (we && a < NADDR) gold[a] = d;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] r, r2;
    int b_rd, b_wr, b_wb, b_own, b_seq;
    hold_off = 1'b0;
    for (int c = 0; c < 2; c++) begin cv[c] = 0; cw[c] = 0; ca[c] = 0; cd[c] = 0; end
    for (int i = 0; i < NADDR; i++) gold[i] = init_val(i);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R10 reset state
    check(!crdy[0] && !crdy[1] && !breq[0] && !breq[1] && !bus_v && !rsp_own, "R10", 1, 0);

    // R2 read miss from reset
    b_rd = n_rd;
    access(0, 0, 5, 0, r);
    check(r == init_val(5), "R2 data", r, init_val(5));
    check(n_rd == b_rd + 1 && last_cyc > 1, "R2 cmd", n_rd - b_rd, 1);
    // R9 one-cycle pulse
    @(negedge clk);
    check(!crdy[0], "R9", crdy[0], 0);
    // R1 read hit
    b_rd = n_rd; b_wr = n_wr;
    access(0, 0, 5, 0, r);
    check(last_cyc == 1 && n_rd == b_rd && n_wr == b_wr && r == init_val(5), "R1 read hit", last_cyc, 1);
    // R3 store to Shared
    access(0, 1, 5, 16'h1111, r);
    check(n_wr == b_wr + 1, "R3 wr-miss on shared", n_wr - b_wr, 1);
    // R1 store hit on Exclusive
    b_wr = n_wr;
    access(0, 1, 5, 16'h2222, r);
    check(last_cyc == 1 && n_wr == b_wr, "R1 write hit", last_cyc, 1);
    // R5 owner supplies dirty data
    check(mem[5] != 16'h2222, "R5 memory stale", mem[5], init_val(5));
    b_own = n_own;
    access(1, 0, 5, 0, r);
    check(r == 16'h2222, "R5 owner data", r, 16'h2222);
    check(n_own == b_own + 1, "R5 own flag", n_own - b_own, 1);
    b_rd = n_rd;
    access(0, 0, 5, 0, r);
    check(last_cyc == 1 && n_rd == b_rd && r == 16'h2222, "R5 stays shared", last_cyc, 1);
    // R4 invalidation by peer write
    access(1, 1, 5, 16'h3333, r);
    b_rd = n_rd;
    access(0, 0, 5, 0, r);
    check(n_rd == b_rd + 1, "R4 miss after invalidate", n_rd - b_rd, 1);
    check(r == 16'h3333, "R4 data", r, 16'h3333);

    // R8 dirty victim
    access(0, 1, 9, 16'h4444, r);
    b_wb = n_wb; b_seq = n_wbseq;
    access(0, 0, 13, 0, r);
    check(n_wb == b_wb + 1 && n_wbseq == b_seq + 1, "R8 writeback", n_wb - b_wb, 1);
    check(wb_addr == 9 && wb_data == 16'h4444, "R8 victim", wb_addr, 9);
    check(r == init_val(13), "R8 new line", r, init_val(13));
    access(0, 0, 9, 0, r);
    check(r == 16'h4444, "R8 reread victim", r, 16'h4444);
    // R8 clean victim
    b_wb = n_wb;
    access(0, 0, 1, 0, r);
    check(n_wb == b_wb, "R8 clean drop", n_wb - b_wb, 0);

    // R6 nothing changes before grant
    access(1, 0, 6, 0, r);
    hold_off = 1'b1;
    fork
      access(0, 1, 6, 16'h5555, r2);
      begin
        repeat (10) @(negedge clk);
        b_rd = n_rd;
        access(1, 0, 6, 0, r);
        check(last_cyc == 1 && n_rd == b_rd && r == init_val(6), "R6 no early change", r, init_val(6));
        hold_off = 1'b0;
      end
    join
    access(1, 0, 6, 0, r);
    check(r == 16'h5555, "R6 completes after grant", r, 16'h5555);
    check(n_nogrant == 0, "R6 commands only with grant", n_nogrant, 0);

    // R7 racing writers
    b_wr = n_wr;
    fork
      access(0, 1, 2, 16'hAAAA, r);
      access(1, 1, 2, 16'hBBBB, r2);
    join
    access(0, 0, 2, 0, r);
    access(1, 0, 2, 0, r2);
    check(r == r2 && (r == 16'hAAAA || r == 16'hBBBB), "R7 serialized", r, r2);
    check(n_wr == b_wr + 2, "R7 two write-misses", n_wr - b_wr, 2);
    gold[2] = r;

    // R11 sweep
    for (int i = 0; i < 240; i++) begin
      int c = (i / 3) % 2;
      int a = (i * 7 + 3) % NADDR;
      bit w = ((i * 5) % 3) == 0;
      logic [DW-1:0] d = DW'(i * 13 + 1);
      logic [DW-1:0] e = gold[a];
      access(c, w, a, d, r);
      if (!w) check(r == e, "R11 sweep", r, e);
    end
    for (int a = 0; a < NADDR; a++) begin
      access(0, 0, a, 0, r);
      access(1, 0, a, 0, r2);
      check(r == gold[a] && r2 == gold[a], "R11 final", r, gold[a]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule